// File: doc/BRIEF.md
# Indirect interrupt redirection register file

This block holds the programmable state of an I/O interrupt router. Software does not see the redirection table directly. It writes an index into a select register, then reads or writes the addressed 32-bit word through a data window. Besides the per-pin redirection entries, the index space holds an identification register, a read-only version word and an arbitration word. The version word reports how many pins the block was built with.

Each pin owns a 64-bit entry, and software reaches it as a lower and an upper 32-bit half. The whole table is exported in parallel to the delivery logic. The delivery logic sets and clears each entry's remote-pending bit with per-pin strobes. When software changes a pin's mask bit, the block raises a one-cycle notification that carries the new mask value. A write to the lower half of an entry always clears the entry's remote-pending flag.

Entry layout:

| Bits | Field |
|---|---|
| [7:0] | vector |
| [10:8] | delivery mode |
| [11] | destination mode |
| [12] | delivery status |
| [13] | polarity |
| [14] | remote pending |
| [15] | trigger mode (1 = level) |
| [16] | mask |
| [63:56] | destination |

All other entry bits are stored as written.

Top module: `ioredir_regs`

## Requirements
- R1: After reset every entry reads 0x0001_0000 in its lower half (mask bit 16 set, all other bits 0) and 0 in its upper half. The select register and the 4-bit ID also reset to 0.
- R2: `bus_addr` is the byte offset inside the block. Offset 0x00 is the select register, which reads back its full 32-bit value. Offset 0x10 is the data window. Any other offset reads as 0, and writes to it change nothing.
- R3: `bus_size` gives the access width in bytes. A write with `bus_size` below 4 is dropped. A write of 4 or more bytes stores `bus_wdata[31:0]`.
- R4: Window index 0x01 reads `(NPINS-1)` in bits [23:16] and the version code `VER` (default 0x11) in bits [7:0], with all other bits 0. With the defaults this is 0x0017_0011. Writes to this index have no effect.
- R5: Window index 0x00 holds the ID. A write loads `wdata[27:24]`, and a read returns the ID in bits [27:24] with 0 elsewhere. Index 0x02 reads the same value, and writes to index 0x02 are ignored.
- R6: A select value S of 0x10 or above addresses entry (S-0x10)>>1. An odd S reaches bits [63:32] of that entry and an even S reaches bits [31:0]. Select values 0x03 to 0x0F read as 0.
- R7: A window access whose computed entry index is NPINS or more writes nothing and reads 0. This covers select values such as 0x40 and 0xFFFF_FFFF.
- R8: A write to the lower half of an entry clears remote pending (bit 14), whatever value is written to that bit. A write to the upper half leaves bit 14 unchanged.
- R9: A pulse on `rp_set[i]` sets bit 14 of entry i, and a pulse on `rp_clr[i]` clears it. If a set arrives in the same cycle as any clear (the strobe or a lower-half write), the bit ends up set.
- R10: In the cycle after a window write that changes entry i's mask bit, `mask_chg[i]` is 1 for exactly one cycle and `mask_new[i]` equals the new mask. A write that leaves the mask unchanged raises no pulse.
- R11: `bus_rdata` is registered. It shows the word selected by `bus_addr` and the register state at the clock edge before it.
- R12: `ent_flat[64*i+63:64*i]` is entry i. It takes a written value at the edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset inside the block |
| bus_we | input | 1 | Write enable |
| bus_size | input | 4 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rp_set | input | NPINS | Per-pin remote-pending set strobe |
| rp_clr | input | NPINS | Per-pin remote-pending clear strobe |
| ent_flat | output | NPINS*64 | All entries, packed by pin |
| mask_chg | output | NPINS | Per-pin mask-change pulse |
| mask_new | output | NPINS | New mask value that goes with the pulse |

## Verification
Two functions can land on the remote-pending bit in the same cycle: a software write to an entry's lower half, which clears it, and a set strobe from the delivery logic. The bench provokes this by driving the window write and `rp_set` for the same pin on the same edge, and by driving the set and clear strobes together. It then reads the lower half back through the window and expects bit 14 to be 1, because the set takes priority.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;
  localparam int unsigned ENT_W    = 64;
  localparam int unsigned WORD_W   = 32;
  localparam logic [7:0]  OFS_SEL  = 8'h00;
  localparam logic [7:0]  OFS_WIN  = 8'h10;
  localparam logic [31:0] IX_ID    = 32'h0;
  localparam logic [31:0] IX_VER   = 32'h1;
  localparam logic [31:0] IX_ARB   = 32'h2;
  localparam logic [31:0] IX_TBL   = 32'h10;
  localparam int unsigned B_RPEND  = 14;
  localparam int unsigned B_MASK   = 16;
  localparam logic [ENT_W-1:0] ENT_RST = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/ioredir_sel.sv
module ioredir_sel #(
  parameter int unsigned NPINS = 24,
  localparam int unsigned IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       addr,
  input  logic             we,
  input  logic [3:0]       size,
  input  logic [31:0]      wdata,
  output logic [31:0]      sel_q,
  output logic [3:0]       id_q,
  output logic             tbl_hit,
  output logic [IDXW-1:0]  tbl_idx,
  output logic             tbl_odd,
  output logic [NPINS-1:0] wr_lo,
  output logic [NPINS-1:0] wr_hi
);
  import ioredir_pkg::*;

  logic        wok, win_wr;
  logic [31:0] idx_full;

  assign wok    = we && (size >= 4'd4);
  assign win_wr = wok && (addr == OFS_WIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (wok && addr == OFS_SEL) begin
      sel_q <= wdata;
    end else if (win_wr && sel_q == IX_ID) begin
      id_q <= wdata[27:24];
    end
  end

  always_comb begin
    idx_full = (sel_q - IX_TBL) >> 1;
    tbl_hit  = (sel_q >= IX_TBL) && (idx_full < NPINS);
    tbl_idx  = idx_full[IDXW-1:0];
    tbl_odd  = sel_q[0];
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_strb
    assign wr_lo[i] = win_wr && tbl_hit && !tbl_odd && (tbl_idx == IDXW'(i));
    assign wr_hi[i] = win_wr && tbl_hit &&  tbl_odd && (tbl_idx == IDXW'(i));
  end
endmodule

// File: rtl/ioredir_entry.sv
module ioredir_entry
  import ioredir_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic             rp_set,
  input  logic             rp_clr,
  output logic [ENT_W-1:0] ent,
  output logic             mchg,
  output logic             mnew
);
  logic [ENT_W-1:0] nxt;

  always_comb begin
    nxt = ent;
    if (wr_lo) nxt[31:0]  = wdata;
    if (wr_hi) nxt[63:32] = wdata;
    if (wr_lo || rp_clr) nxt[B_RPEND] = 1'b0;
    if (rp_set)          nxt[B_RPEND] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent  <= ENT_RST;
      mchg <= 1'b0;
      mnew <= 1'b1;
    end else begin
      ent  <= nxt;
      mchg <= nxt[B_MASK] != ent[B_MASK];
      mnew <= nxt[B_MASK];
    end
  end
endmodule

// File: rtl/ioredir_regs.sv
module ioredir_regs #(
  parameter int unsigned NPINS = 24,
  parameter logic [7:0]  VER   = 8'h11,
  localparam int unsigned IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          bus_addr,
  input  logic                bus_we,
  input  logic [3:0]          bus_size,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NPINS-1:0]    rp_set,
  input  logic [NPINS-1:0]    rp_clr,
  output logic [NPINS*64-1:0] ent_flat,
  output logic [NPINS-1:0]    mask_chg,
  output logic [NPINS-1:0]    mask_new
);
  import ioredir_pkg::*;

  logic [31:0]      sel_q;
  logic [3:0]       id_q;
  logic             tbl_hit, tbl_odd;
  logic [IDXW-1:0]  tbl_idx;
  logic [NPINS-1:0] wr_lo, wr_hi;
  logic [ENT_W-1:0] ent_arr [NPINS];
  logic [ENT_W-1:0] ent_pick;
  logic [31:0]      rd_nxt;

  ioredir_sel #(.NPINS(NPINS)) u_sel (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .size(bus_size),
    .wdata(bus_wdata), .sel_q(sel_q), .id_q(id_q), .tbl_hit(tbl_hit),
    .tbl_idx(tbl_idx), .tbl_odd(tbl_odd), .wr_lo(wr_lo), .wr_hi(wr_hi)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    ioredir_entry u_ent (
      .clk(clk), .rst(rst), .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]),
      .wdata(bus_wdata), .rp_set(rp_set[i]), .rp_clr(rp_clr[i]),
      .ent(ent_arr[i]), .mchg(mask_chg[i]), .mnew(mask_new[i])
    );
    assign ent_flat[64*i +: 64] = ent_arr[i];
  end

  always_comb begin
    ent_pick = '0;
    for (int i = 0; i < NPINS; i++)
      if (tbl_idx == IDXW'(i)) ent_pick = ent_arr[i];
  end

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == OFS_SEL) begin
      rd_nxt = sel_q;
    end else if (bus_addr == OFS_WIN) begin
      if (sel_q == IX_ID || sel_q == IX_ARB)
        rd_nxt = {4'h0, id_q, 24'h0};
      else if (sel_q == IX_VER)
        rd_nxt = {8'h00, 8'(NPINS - 1), 8'h00, VER};
      else if (tbl_hit)
        rd_nxt = tbl_odd ? ent_pick[63:32] : ent_pick[31:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/ioredir_chk.sv
module ioredir_chk #(
  parameter int unsigned NPINS = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [7:0]          bus_addr,
  input logic                bus_we,
  input logic [3:0]          bus_size,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NPINS-1:0]    rp_set,
  input logic [NPINS-1:0]    rp_clr,
  input logic [NPINS*64-1:0] ent_flat,
  input logic [NPINS-1:0]    mask_chg,
  input logic [NPINS-1:0]    mask_new
);
  logic [NPINS-1:0] masks;
  logic             wr_ok;

  for (genvar i = 0; i < NPINS; i++) begin : g_m
    assign masks[i] = ent_flat[64*i + 16];
  end
  assign wr_ok = bus_we && (bus_size >= 4'd4);

  a_r1_masks_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (masks == {NPINS{1'b1}}));

  a_r2_other_offset_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != 8'h00 && bus_addr != 8'h10) |=> (bus_rdata == 32'h0));

  a_r3_no_write_no_mask_move: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> $stable(masks));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      rp_set[i] |=> ent_flat[64*i + 14]);

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
      (rp_clr[i] && !rp_set[i]) |=> !ent_flat[64*i + 14]);

    a_r10_pulse_carries_mask: assert property (@(posedge clk) disable iff (rst)
      mask_chg[i] |-> (mask_new[i] == masks[i]));

    a_r10_pulse_means_change: assert property (@(posedge clk) disable iff (rst)
      mask_chg[i] |-> (masks[i] != $past(masks[i])));
  end
endmodule

bind ioredir_regs ioredir_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/sim_ioredir_regs.sv
module sim_ioredir_regs;
  localparam int NP = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [3:0]    bus_size = 4'd4;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] rp_set = '0, rp_clr = '0;
  logic [NP*64-1:0] ent_flat;
  logic [NP-1:0] mask_chg, mask_new;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ioredir_regs #(.NPINS(NP)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rp_set(rp_set), .rp_clr(rp_clr), .ent_flat(ent_flat),
    .mask_chg(mask_chg), .mask_new(mask_new)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic sel(input logic [31:0] s);
    wr(8'h00, 4'd4, s);
  endtask

  task automatic rdw(input logic [31:0] s, output logic [31:0] d);
    sel(s);
    rd(8'h10, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    int nm = 0;
    for (int i = 0; i < NP; i++) nm += int'(ent_flat[64*i+16]);
    chk("R1 all masks set", 64'(nm), 64'(NP));
    rd(8'h00, d);          chk("R1 select reset", 64'(d), 64'h0);
    rd(8'h10, d);          chk("R1 id reset", 64'(d), 64'h0);
    rdw(32'h11, d);        chk("R1 entry0 upper", 64'(d), 64'h0);
    rdw(32'h2E, d);        chk("R1 entry15 lower", 64'(d), 64'h0001_0000);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    logic [NP*64-1:0] snap;
    sel(32'h12);
    snap = ent_flat;
    wr(8'h04, 4'd4, 32'h99);
    wr(8'h20, 4'd4, 32'hFFFF_FFFF);
    rd(8'h00, d);          chk("R2 stray writes keep select", 64'(d), 64'h12);
    chk("R2 stray writes keep table", 64'(ent_flat == snap), 64'h1);
    rd(8'h20, d);          chk("R2 offset 0x20 reads 0", 64'(d), 64'h0);
    rd(8'h08, d);          chk("R2 offset 0x08 reads 0", 64'(d), 64'h0);
  endtask

  task automatic t_size;
    logic [31:0] d;
    sel(32'h1);
    wr(8'h00, 4'd2, 32'h33);
    rd(8'h00, d);          chk("R3 2-byte write dropped", 64'(d), 64'h1);
    wr(8'h00, 4'd1, 32'h34);
    rd(8'h00, d);          chk("R3 1-byte write dropped", 64'(d), 64'h1);
    wr(8'h00, 4'd8, 32'h2);
    rd(8'h00, d);          chk("R3 8-byte write taken", 64'(d), 64'h2);
  endtask

  task automatic t_version;
    logic [31:0] d;
    rdw(32'h1, d);         chk("R4 version word", 64'(d), 64'h0017_0011);
    wr(8'h10, 4'd4, 32'hFFFF_FFFF);
    rd(8'h10, d);          chk("R4 version write ignored", 64'(d), 64'h0017_0011);
  endtask

  task automatic t_id;
    logic [31:0] d;
    sel(32'h0);
    wr(8'h10, 4'd4, 32'hA5FF_FFFF);
    rd(8'h10, d);          chk("R5 id loads bits 27:24", 64'(d), 64'h0500_0000);
    rdw(32'h2, d);         chk("R5 arb mirrors id", 64'(d), 64'h0500_0000);
    wr(8'h10, 4'd4, 32'h0F00_0000);
    rdw(32'h0, d);         chk("R5 arb write ignored", 64'(d), 64'h0500_0000);
  endtask

  task automatic t_table;
    logic [31:0] d;
    sel(32'h1A);
    wr(8'h10, 4'd4, 32'h0000_A031);
    sel(32'h1B);
    wr(8'h10, 4'd4, 32'hAB00_0000);
    chk("R12 export entry5", ent_flat[5*64 +: 64], 64'hAB00_0000_0000_A031);
    rdw(32'h1A, d);        chk("R6 entry5 lower", 64'(d), 64'h0000_A031);
    rdw(32'h1B, d);        chk("R6 entry5 upper", 64'(d), 64'hAB00_0000);
    sel(32'h3E);
    wr(8'h10, 4'd4, 32'h0001_0077);
    rd(8'h10, d);          chk("R6 last entry lower", 64'(d), 64'h0001_0077);
    chk("R12 export entry23", ent_flat[23*64 +: 64], 64'h0000_0000_0001_0077);
    rdw(32'h5, d);         chk("R6 reserved index reads 0", 64'(d), 64'h0);
  endtask

  task automatic t_range;
    logic [31:0] d;
    logic [NP*64-1:0] snap;
    snap = ent_flat;
    sel(32'h40);
    wr(8'h10, 4'd4, 32'h1234_5678);
    rd(8'h10, d);          chk("R7 index 24 reads 0", 64'(d), 64'h0);
    sel(32'hFFFF_FFFF);
    wr(8'h10, 4'd4, 32'h1234_5678);
    rd(8'h10, d);          chk("R7 huge select reads 0", 64'(d), 64'h0);
    chk("R7 table untouched", 64'(ent_flat == snap), 64'h1);
  endtask

  task automatic t_rpend;
    logic [31:0] d;
    @(negedge clk); rp_set[5] = 1'b1;
    @(negedge clk); rp_set[5] = 1'b0;
    rdw(32'h1A, d);        chk("R9 set strobe", 64'(d), 64'h0000_E031);
    sel(32'h1B);
    wr(8'h10, 4'd4, 32'hAB00_0000);
    rdw(32'h1A, d);        chk("R8 upper write keeps pending", 64'(d), 64'h0000_E031);
    wr(8'h10, 4'd4, 32'h0000_E031);
    rd(8'h10, d);          chk("R8 lower write clears pending", 64'(d), 64'h0000_A031);
    @(negedge clk); rp_set[5] = 1'b1;
    @(negedge clk); rp_set[5] = 1'b0; rp_clr[5] = 1'b1;
    @(negedge clk); rp_clr[5] = 1'b0;
    rd(8'h10, d);          chk("R9 clear strobe", 64'(d), 64'h0000_A031);
  endtask

  task automatic t_race;
    logic [31:0] d;
    sel(32'h1A);
    @(negedge clk);
    bus_addr = 8'h10; bus_size = 4'd4; bus_wdata = 32'h0000_A031;
    bus_we = 1'b1; rp_set[5] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; rp_set[5] = 1'b0;
    rd(8'h10, d);          chk("R9 set beats lower write", 64'(d), 64'h0000_E031);
    wr(8'h10, 4'd4, 32'h0000_A031);
    @(negedge clk); rp_set[5] = 1'b1; rp_clr[5] = 1'b1;
    @(negedge clk); rp_set[5] = 1'b0; rp_clr[5] = 1'b0;
    rd(8'h10, d);          chk("R9 set beats clear strobe", 64'(d), 64'h0000_E031);
  endtask

  task automatic t_maskchg;
    sel(32'h1E);
    wr(8'h10, 4'd4, 32'h0000_0040);
    chk("R10 unmask pulse", 64'(mask_chg), 64'(NP'(1) << 7));
    chk("R10 new mask 0", 64'(mask_new[7]), 64'h0);
    @(negedge clk);
    chk("R10 pulse one cycle", 64'(mask_chg), 64'h0);
    wr(8'h10, 4'd4, 32'h0000_0041);
    chk("R10 no pulse when unchanged", 64'(mask_chg), 64'h0);
    wr(8'h10, 4'd4, 32'h0001_0041);
    chk("R10 mask pulse", 64'(mask_chg), 64'(NP'(1) << 7));
    chk("R10 new mask 1", 64'(mask_new[7]), 64'h1);
  endtask

  task automatic t_rdreg;
    logic [31:0] d;
    sel(32'h1E);
    @(negedge clk); bus_addr = 8'h10;
    @(posedge clk); #1;
    chk("R11 read registered after edge", 64'(bus_rdata), 64'h0001_0041);
    bus_addr = 8'h30;
    #2;
    chk("R11 read holds until next edge", 64'(bus_rdata), 64'h0001_0041);
    rd(8'h30, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_size();
    t_version();
    t_id();
    t_table();
    t_range();
    t_rpend();
    t_race();
    t_maskchg();
    t_rdreg();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule